// File: doc/BRIEF.md
# Low-Speed Clock Source Controller

This block holds the control state that chooses where the low-speed clock comes from: an internal RC oscillator or an external crystal. Software reaches it through a small register port with a write strobe, an address and write data, and a combinational read path. It decides which source is in use, starts a switch-over to the crystal, and watches a crystal-alive indication from the analog side. It does not model the oscillators or the clock multiplexer.

A switch-over is started by writing 1 to a command bit. The bit clears itself after a short fixed sequence, and completion is reported through a sticky flag and an interrupt. While crystal mode is selected, a crystal-alive input that stays low for too long counts as a failure. A failure sets a sticky flag, raises an interrupt when enabled and puts the mode back to RC, even while the mode field is locked.

The mode field is locked whenever the oscillator enable bit is set. A halt-exit pulse forces the oscillator enable and the high-speed system clock select to 1.

Top module: `lsclk_ctrl_top`

## Requirements
- R1: After reset, every readable field is 0 and all four outputs are 0.
- R2: The 2-bit mode field is at address 0, bits [1:0], and 00 means RC. A write to it takes effect only while oscEn (address 1, bit 0) is 0. While oscEn is 1 the old value is kept.
- R3: A write of 0 to the start command bit (address 2, bit 0) has no effect.
- R4: A write of 1 to the start command bit makes it read 1 for exactly two cycles, and it then returns to 0 by itself. A write of 1 while the bit is already 1 does not restart the sequence.
- R5: When the start sequence ends, the done flag (address 3, bit 1) sets. lsClkXtal (also readable at address 3, bit 2) becomes 1 if the mode is not 00. doneIrq equals the done flag AND doneIe (address 4, bit 1). lsClkXtal is 0 whenever the mode is 00.
- R6: While the mode is not 00, xtalAlive sampled low on 8 consecutive clock edges sets the fail flag (address 3, bit 0), forces the mode to 00 even when it is locked, and clears lsClkXtal. A run of 7 low samples does nothing.
- R7: The fail and done flags are sticky and are cleared only by writing 1 to their bit at address 3. Writing 0 leaves them unchanged. A new set in the same cycle wins over a clear. failIrq equals the fail flag AND failIe (address 4, bit 0).
- R8: A haltExit pulse sets oscEn and sysSel (address 1, bit 1) to 1 on the next edge, and this wins over a bus write to address 1 in the same cycle.
- R9: Address 4 holds failIe and doneIe and can be read back. Unused bits read 0, and addresses 5 to 7 read 0.
- R10: sysClkHigh always follows the sysSel bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (RC-derived) |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| xtalAlive | input | 1 | Crystal oscillation present |
| haltExit | input | 1 | One-cycle pulse on leaving high-level halt |
| lsClkXtal | output | 1 | Low-speed clock is taken from the crystal |
| sysClkHigh | output | 1 | System clock select (1 = high-speed) |
| failIrq | output | 1 | Crystal failure interrupt (level) |
| doneIrq | output | 1 | Switch-over completion interrupt (level) |

## Verification
The assertions assume that all inputs are synchronous to clk, that haltExit may occur in any cycle, and that a write can land on any address in any cycle, including while the lock or the start sequence is active. The bench drives every input just after a rising edge, so the values are steady when the design samples them. Its xtalAlive stimulus mixes long high periods with phases of frequent low samples, so that runs of 7 and of 8 consecutive lows both occur. Random writes cover every address, including the unmapped ones. These writes collide with lock, halt exit and failure forcing in the same cycle.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
  // register addresses
  localparam int unsigned REG_MODE  = 0;
  localparam int unsigned REG_CTRL  = 1;
  localparam int unsigned REG_CMD   = 2;
  localparam int unsigned REG_STAT  = 3;
  localparam int unsigned REG_IRQEN = 4;

  // sticky flag slots inside the status register
  localparam int unsigned FLAG_FAIL = 0;
  localparam int unsigned FLAG_DONE = 1;
  localparam int unsigned FLAG_N    = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic modeWr;
    logic ctrlWr;
    logic irqEnWr;
    logic failClr;
    logic doneClr;
    logic startDone;
    logic failHit;
  } lsStrobe_t;
endpackage

// File: rtl/lsclk_ctrl.sv
module lsclk_ctrl
  import lsclk_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int FAIL_LIMIT   = 8,
  parameter int START_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        cmdBits,
  input  logic              xtalAlive,
  input  logic              xtalModeSel,
  output lsStrobe_t         strb,
  output logic              startBusy
);
  localparam int LOW_W = (FAIL_LIMIT > 1) ? $clog2(FAIL_LIMIT) : 1;
  localparam int SEQ_W = (START_CYCLES > 1) ? $clog2(START_CYCLES) : 1;
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(FAIL_LIMIT - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(START_CYCLES - 1);

  logic [LOW_W-1:0] lowCnt;
  logic [SEQ_W-1:0] seqCnt;
  logic             busyQ;
  logic             wrMode, wrCtrl, wrCmd, wrStat, wrIrqEn;
  logic             startReq, seqDone, failHit;

  // address decode
  always_comb begin
    wrMode  = busWrEn && (busAddr == ADDR_W'(REG_MODE));
    wrCtrl  = busWrEn && (busAddr == ADDR_W'(REG_CTRL));
    wrCmd   = busWrEn && (busAddr == ADDR_W'(REG_CMD));
    wrStat  = busWrEn && (busAddr == ADDR_W'(REG_STAT));
    wrIrqEn = busWrEn && (busAddr == ADDR_W'(REG_IRQEN));
  end

  // crystal failure monitor: consecutive low samples in crystal mode
  assign failHit = xtalModeSel && !xtalAlive && (lowCnt == LOW_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (!xtalModeSel || xtalAlive || failHit) begin
      lowCnt <= '0;
    end else begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // switch-over start sequencer; zero writes never start it
  assign startReq = wrCmd && cmdBits[0] && !busyQ;
  assign seqDone  = busyQ && (seqCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      seqCnt <= '0;
    end else if (startReq) begin
      busyQ  <= 1'b1;
      seqCnt <= SEQ_LAST;
    end else if (busyQ) begin
      if (seqCnt == '0) begin
        busyQ <= 1'b0;
      end else begin
        seqCnt <= seqCnt - 1'b1;
      end
    end
  end

  assign startBusy = busyQ;

  always_comb begin
    strb           = '0;
    strb.modeWr    = wrMode;
    strb.ctrlWr    = wrCtrl;
    strb.irqEnWr   = wrIrqEn;
    strb.failClr   = wrStat && cmdBits[0];
    strb.doneClr   = wrStat && cmdBits[1];
    strb.startDone = seqDone;
    strb.failHit   = failHit;
  end
endmodule

// File: rtl/lsclk_regfile.sv
module lsclk_regfile
  import lsclk_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int MODE_W = 2,
  parameter int WB_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsStrobe_t         strb,
  input  logic [WB_W-1:0]   wrBits,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              haltExit,
  input  logic              startBusy,
  output logic [MODE_W-1:0] lsMode,
  output logic              oscEn,
  output logic              sysSel,
  output logic              failFlag,
  output logic              doneFlag,
  output logic              usingXtal,
  output logic              failIe,
  output logic              doneIe,
  output logic [DATA_W-1:0] busRdata
);
  logic [MODE_W-1:0] modeNext;
  logic [FLAG_N-1:0] flagQ, flagSet, flagClr;

  // mode field: failure forcing beats the lock, the lock beats a write
  always_comb begin
    modeNext = lsMode;
    if (strb.failHit) begin
      modeNext = '0;
    end else if (strb.modeWr && !oscEn) begin
      modeNext = wrBits[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsMode    <= '0;
      usingXtal <= 1'b0;
    end else begin
      lsMode <= modeNext;
      if (modeNext == '0) begin
        usingXtal <= 1'b0;
      end else if (strb.startDone) begin
        usingXtal <= 1'b1;
      end
    end
  end

  // control bits; halt exit wins over a bus write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscEn  <= 1'b0;
      sysSel <= 1'b0;
    end else if (haltExit) begin
      oscEn  <= 1'b1;
      sysSel <= 1'b1;
    end else if (strb.ctrlWr) begin
      oscEn  <= wrBits[0];
      sysSel <= wrBits[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failIe <= 1'b0;
      doneIe <= 1'b0;
    end else if (strb.irqEnWr) begin
      failIe <= wrBits[0];
      doneIe <= wrBits[1];
    end
  end

  // sticky flags, write-one-to-clear, set has priority
  assign flagSet[FLAG_FAIL] = strb.failHit;
  assign flagSet[FLAG_DONE] = strb.startDone;
  assign flagClr[FLAG_FAIL] = strb.failClr;
  assign flagClr[FLAG_DONE] = strb.doneClr;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[g] <= 1'b0;
      end else if (flagSet[g]) begin
        flagQ[g] <= 1'b1;
      end else if (flagClr[g]) begin
        flagQ[g] <= 1'b0;
      end
    end
  end

  assign failFlag = flagQ[FLAG_FAIL];
  assign doneFlag = flagQ[FLAG_DONE];

  // readback
  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(REG_MODE):  busRdata[MODE_W-1:0] = lsMode;
      ADDR_W'(REG_CTRL):  busRdata[1:0] = {sysSel, oscEn};
      ADDR_W'(REG_CMD):   busRdata[0] = startBusy;
      ADDR_W'(REG_STAT):  busRdata[2:0] = {usingXtal, doneFlag, failFlag};
      ADDR_W'(REG_IRQEN): busRdata[1:0] = {doneIe, failIe};
      default:            busRdata = '0;
    endcase
  end
endmodule

// File: rtl/lsclk_ctrl_top.sv
module lsclk_ctrl_top
  import lsclk_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 8,
  parameter int MODE_W       = 2,
  parameter int FAIL_LIMIT   = 8,
  parameter int START_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              xtalAlive,
  input  logic              haltExit,
  output logic              lsClkXtal,
  output logic              sysClkHigh,
  output logic              failIrq,
  output logic              doneIrq
);
  localparam int WB_W = (MODE_W > 2) ? MODE_W : 2;

  lsStrobe_t         strb;
  logic [MODE_W-1:0] lsMode;
  logic              oscEn, sysSel, failFlag, doneFlag, usingXtal;
  logic              failIe, doneIe, startBusy;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:WB_W];

  lsclk_ctrl #(
    .ADDR_W(ADDR_W), .FAIL_LIMIT(FAIL_LIMIT), .START_CYCLES(START_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .cmdBits(busWdata[1:0]), .xtalAlive(xtalAlive),
    .xtalModeSel(lsMode != '0), .strb(strb), .startBusy(startBusy)
  );

  lsclk_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .WB_W(WB_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBits(busWdata[WB_W-1:0]),
    .busAddr(busAddr), .haltExit(haltExit), .startBusy(startBusy),
    .lsMode(lsMode), .oscEn(oscEn), .sysSel(sysSel), .failFlag(failFlag),
    .doneFlag(doneFlag), .usingXtal(usingXtal), .failIe(failIe),
    .doneIe(doneIe), .busRdata(busRdata)
  );

  assign lsClkXtal  = usingXtal;
  assign sysClkHigh = sysSel;
  assign failIrq    = failFlag && failIe;
  assign doneIrq    = doneFlag && doneIe;
endmodule

// File: rtl/lsclk_checker.sv
module lsclk_checker
  import lsclk_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              haltExit,
  input logic [MODE_W-1:0] lsMode,
  input logic              oscEn,
  input logic              sysClkHigh,
  input logic              startBusy,
  input logic              failFlag,
  input logic              lsClkXtal
);
  // R2: locked mode keeps its value unless a failure forces RC
  a_r2_mode_locked: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr == ADDR_W'(REG_MODE)) && oscEn
      |=> (lsMode == $past(lsMode)) || (lsMode == '0));

  // R3: zero write to the idle command bit does nothing
  a_r3_zero_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr == ADDR_W'(REG_CMD)) && !busWdata[0] && !startBusy
      |=> !startBusy);

  // R4: command bit lives exactly two cycles
  a_r4_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startBusy) |=> startBusy ##1 !startBusy);

  // R5: crystal indication only with a crystal mode
  a_r5_xtal_needs_mode: assert property (@(posedge clk) disable iff (!rstN)
    lsClkXtal |-> (lsMode != '0));

  // R6: failure puts the mode back to RC
  a_r6_fail_to_rc: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> (lsMode == '0));

  // R7: failure flag stays until a write of one clears it
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    failFlag && !(busWrEn && (busAddr == ADDR_W'(REG_STAT)) && busWdata[0])
      |=> failFlag);

  // R8: halt exit forces enable and system select
  a_r8_halt_force: assert property (@(posedge clk) disable iff (!rstN)
    haltExit |=> oscEn && sysClkHigh);
endmodule

bind lsclk_ctrl_top lsclk_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWdata(busWdata), .haltExit(haltExit), .lsMode(lsMode),
  .oscEn(oscEn), .sysClkHigh(sysClkHigh), .startBusy(startBusy),
  .failFlag(failFlag), .lsClkXtal(lsClkXtal)
);

// File: tb/test_lsclk_ctrl_top.sv
module test_lsclk_ctrl_top;
  localparam int CLK_PERIOD = 10;
  localparam int FAIL_N     = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       xtalAlive = 1'b1;
  logic       haltExit = 1'b0;
  logic       lsClkXtal, sysClkHigh, failIrq, doneIrq;

  int nCompared = 0;
  int nMismatch = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsclk_ctrl_top i_lsclk_ctrl_top (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .xtalAlive(xtalAlive),
    .haltExit(haltExit), .lsClkXtal(lsClkXtal), .sysClkHigh(sysClkHigh),
    .failIrq(failIrq), .doneIrq(doneIrq)
  );

  // behavioural reference state
  int mMode, mBusyLeft, mLow;
  bit mOsc, mSys, mFail, mDone, mXtal, mFie, mDie;

  function automatic bit wrAt(int a);
    return busWrEn && (int'(busAddr) == a);
  endfunction

  always @(posedge clk) begin
    bit fNow, dNow;
    int nMode;
    if (!rstN) begin
      mMode = 0; mBusyLeft = 0; mLow = 0;
      mOsc = 0; mSys = 0; mFail = 0; mDone = 0; mXtal = 0; mFie = 0; mDie = 0;
    end else begin
      fNow = (mMode != 0) && !xtalAlive && (mLow == FAIL_N - 1);
      if ((mMode != 0) && !xtalAlive && !fNow) mLow++;
      else mLow = 0;
      dNow = (mBusyLeft == 1);
      if (mBusyLeft > 0) mBusyLeft--;
      else if (wrAt(2) && busWdata[0]) mBusyLeft = 2;
      nMode = mMode;
      if (fNow) nMode = 0;
      else if (wrAt(0) && !mOsc) nMode = int'(busWdata[1:0]);
      if (nMode == 0) mXtal = 0;
      else if (dNow) mXtal = 1;
      mMode = nMode;
      if (haltExit) begin mOsc = 1; mSys = 1; end
      else if (wrAt(1)) begin mOsc = busWdata[0]; mSys = busWdata[1]; end
      if (fNow) mFail = 1; else if (wrAt(3) && busWdata[0]) mFail = 0;
      if (dNow) mDone = 1; else if (wrAt(3) && busWdata[1]) mDone = 0;
      if (wrAt(4)) begin mFie = busWdata[0]; mDie = busWdata[1]; end
    end
  end

  function automatic int modelRead(int a);
    case (a)
      0: return mMode;
      1: return {30'd0, mSys, mOsc};
      2: return (mBusyLeft > 0) ? 1 : 0;
      3: return {29'd0, mXtal, mDone, mFail};
      4: return {30'd0, mDie, mFie};
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nCompared++;
    if (act != exp) begin
      nMismatch++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string rsTag);
    check({rsTag, " R9 busRdata"}, int'(busRdata), modelRead(int'(busAddr)));
    check({rsTag, " R5 lsClkXtal"}, int'(lsClkXtal), int'(mXtal));
    check({rsTag, " R10 sysClkHigh"}, int'(sysClkHigh), int'(mSys));
    check({rsTag, " R7 failIrq"}, int'(failIrq), int'(mFail && mFie));
    check({rsTag, " R5 doneIrq"}, int'(doneIrq), int'(mDone && mDie));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    compareAll("clk");
  endtask

  task automatic busWrite(input int a, input int d);
    busWrEn = 1'b1; busAddr = 3'(a); busWdata = 8'(d);
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic expectReg(input int a, input int exp, input string tag);
    busWrEn = 1'b0; busAddr = 3'(a);
    #1;
    check(tag, int'(busRdata), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nMismatch++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    for (int a = 0; a < 8; a++) expectReg(a, 0, "R1 reset readback");
    check("R1 lsClkXtal", int'(lsClkXtal), 0);
    check("R1 sysClkHigh", int'(sysClkHigh), 0);
    check("R1 failIrq", int'(failIrq), 0);
    check("R1 doneIrq", int'(doneIrq), 0);
    rstN = 1'b1;
    started = 1;
    tick();

    // R9: interrupt enables read back
    busWrite(4, 8'hFF);
    expectReg(4, 3, "R9 irq enable readback");
    // R2: mode write accepted when unlocked, ignored when locked
    busWrite(1, 0);
    busWrite(0, 8'hFD);
    expectReg(0, 1, "R2 unlocked write");
    busWrite(1, 1);
    busWrite(0, 2);
    expectReg(0, 1, "R2 locked write ignored");
    // R3: zero write ignored
    busWrite(2, 8'hFE);
    expectReg(2, 0, "R3 zero write");
    // R4: two-cycle self clear, no restart
    busWrite(2, 1);
    expectReg(2, 1, "R4 first cycle");
    busWrite(2, 1);
    expectReg(2, 1, "R4 second cycle");
    tick();
    expectReg(2, 0, "R4 cleared");
    // R5: completion
    expectReg(3, 6, "R5 done and xtal");
    check("R5 doneIrq", int'(doneIrq), 1);
    check("R5 lsClkXtal", int'(lsClkXtal), 1);

    // R6: seven lows tolerated, eight fail
    xtalAlive = 1'b0;
    repeat (7) tick();
    xtalAlive = 1'b1;
    tick();
    expectReg(3, 6, "R6 seven lows");
    xtalAlive = 1'b0;
    repeat (7) tick();
    expectReg(3, 6, "R6 before eighth");
    tick();
    expectReg(3, 3, "R6 failure status");
    expectReg(0, 0, "R6 mode forced to RC");
    check("R6 lsClkXtal", int'(lsClkXtal), 0);
    check("R7 failIrq", int'(failIrq), 1);
    xtalAlive = 1'b1;

    // R7: sticky, write-one-to-clear
    busWrite(3, 0);
    expectReg(3, 3, "R7 zero write keeps");
    busWrite(3, 1);
    expectReg(3, 2, "R7 clear fail only");
    check("R7 failIrq cleared", int'(failIrq), 0);

    // R8: halt exit beats a simultaneous write
    haltExit = 1'b1;
    busWrite(1, 0);
    haltExit = 1'b0;
    expectReg(1, 3, "R8 halt exit forcing");
    check("R10 sysClkHigh set", int'(sysClkHigh), 1);
    busWrite(1, 1);
    check("R10 sysClkHigh cleared", int'(sysClkHigh), 0);

    // R9: unmapped addresses
    for (int a = 5; a < 8; a++) expectReg(a, 0, "R9 unmapped");

    // mixed stimulus compared every clock against the model
    for (int i = 0; i < 3000; i++) begin
      busWrEn  = ($urandom % 4) == 0;
      busAddr  = 3'($urandom % 8);
      busWdata = 8'($urandom);
      haltExit = ($urandom % 40) == 0;
      if (((i / 60) % 3) == 1) xtalAlive = ($urandom % 10) == 0;
      else if (((i / 60) % 3) == 2) xtalAlive = ($urandom % 3) != 0;
      else xtalAlive = 1'b1;
      tick();
    end
    busWrEn = 1'b0; haltExit = 1'b0; xtalAlive = 1'b1;
    tick();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule